// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a multi-bank on-chip scratchpad that serves one warp-wide request at a time. Each lane of the request carries a word address, a write flag, write data and a valid bit. The block works out which bank each lane's word lives in. Lanes whose words fall in different banks are served in the same cycle. When two or more lanes need different words from one bank, the request is split into serial bank passes, and the number of passes equals the deepest conflict. Lanes that ask for the very same word share a single access. For reads, this broadcasts the word to all of those lanes.

A mode input chooses how words are spread over the banks. In narrow mode, each bank holds 32-bit words. In wide mode, each bank holds 64-bit words, so both halves of a 64-bit pair are one bank word. The handshake is plain: a request is taken while `busy` is low. `done` pulses once when every lane has been served, and the per-lane read data stays on `rdata` until the next request is taken. The bank count (32 by default, 16 also supported), the lane count and the address width are parameters.

Top module: `sp_scratchpad`

## Requirements
- R1: With `wide_mode`=0, lane bank = address mod BANKS. A request whose active lanes all use different banks completes in exactly one pass.
- R2: A pass is one clock cycle with `busy` high after the accepting edge. A request whose worst bank holds N distinct words takes exactly N passes. `done` is high in the cycle after the last pass, and `busy` is low in that cycle.
- R3: Active lanes that read the identical address are served in the same pass, and each of them receives that word.
- R4: With `wide_mode`=1, bank = (address >> 1) mod BANKS, and addresses 2k and 2k+1 form one bank word. A stride-2 read of 32 lanes with 32 banks takes 1 pass in this mode and 2 passes with `wide_mode`=0.
- R5: A stride-3 access over all lanes takes one pass, because 3 does not divide the bank count.
- R6: In each pass, every bank serves its lowest-numbered pending lane, together with all pending lanes that share that lane's bank word. A read in a pass returns the value the word held before that pass's writes.
- R7: When several lanes write the same address in one pass, the highest-numbered lane's data is stored.
- R8: A lane with its `req_mask` bit at 0 writes nothing, adds no pass, and has `rdata` equal to 0.
- R9: `rdata` is cleared when a request is accepted. Only active read lanes load data, so write lanes read 0. The values hold after `done` until the next acceptance.
- R10: `req_valid` is ignored while `busy` is high. Such a request writes nothing.
- R11: `done` is a single-cycle pulse. A request with no active lane takes one pass.
- R12: After reset, `busy`, `done` and all of `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_mask | input | LANES | Per-lane active bit |
| req_we | input | LANES | Per-lane write flag (1 = write) |
| req_addr | input | LANES*AW | Lane i word address at bits [i*AW +: AW] |
| req_wdata | input | LANES*32 | Lane i write data at bits [i*32 +: 32] |
| wide_mode | input | 1 | 0 = 32-bit bank words, 1 = 64-bit bank words |
| busy | output | 1 | A request is being served |
| done | output | 1 | One-cycle pulse when the request is complete |
| rdata | output | LANES*32 | Lane i read data at bits [i*32 +: 32] |

## Verification
The bench targets the cases where the pass count differs from a naive count.

- **Identical-address broadcast:** a design without it would spend 32 passes on 32 lanes reading one word.
- **Interleave modes:** the stride-2 pattern is run in both modes. A design that ignores the mode reports 2 passes where 1 is due.
- **Mixed conflicts:** a bank holding a read and a write to one word, plus a write to another word, shows whether reads see pre-pass data and whether the lowest lane leads.
- **Same-address writes:** these show whether the last write goes to the highest lane.
- **Inactive lanes:** masked-off lanes that collide with active ones catch a design that counts them or lets them write.
- **Requests during busy:** a request raised mid-operation catches a design that takes it.

// File: rtl/sp_pkg.sv
// Shared constants and types of the banked scratchpad.
// Assumes 32-bit data lanes throughout.
package sp_pkg;
    localparam int DW = 32;

    typedef enum logic {
        IL_NARROW = 1'b0,
        IL_WIDE   = 1'b1
    } ilv_mode_e;
endpackage

// File: rtl/sp_bank_map.sv
// Maps each lane's word address onto a bank number and a bank-word key.
// Narrow mode: bank from address bits [BW-1:0], key is the full address.
// Wide mode: a 64-bit pair is one bank word, so the bank comes from bits [BW:1]
// and the key drops bit 0. Assumes BANKS is a power of two and AW > BW.
module sp_bank_map #(
    parameter int LANES = 32,
    parameter int AW    = 9,
    parameter int BW    = 5
) (
    input  logic [LANES*AW-1:0] addr_flat,
    input  logic                wide,
    output logic [LANES*BW-1:0] bank_flat,
    output logic [LANES*AW-1:0] key_flat
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [AW-1:0] a;
        assign a = addr_flat[i*AW +: AW];
        // Per-lane bank select and key, chosen by interleave mode.
        always_comb begin
            if (wide) begin
                bank_flat[i*BW +: BW] = a[BW:1];
                key_flat[i*AW +: AW]  = {1'b0, a[AW-1:1]};
            end else begin
                bank_flat[i*BW +: BW] = a[BW-1:0];
                key_flat[i*AW +: AW]  = a;
            end
        end
    end
endmodule

// File: rtl/sp_grant.sv
// Chooses the lanes served in the current pass. For every lane, the lowest
// pending lane in its bank is the bank's leader; a pending lane is granted
// when its key equals the leader's key. Purely combinational.
module sp_grant #(
    parameter int LANES = 32,
    parameter int AW    = 9,
    parameter int BW    = 5
) (
    input  logic [LANES-1:0]    pending,
    input  logic [LANES*BW-1:0] bank_flat,
    input  logic [LANES*AW-1:0] key_flat,
    output logic [LANES-1:0]    grant
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [AW-1:0] lead_key;
        // Scan downward so the lowest pending lane in the same bank is kept last.
        always_comb begin
            lead_key = key_flat[i*AW +: AW];
            for (int j = LANES - 1; j >= 0; j--) begin
                if (pending[j] && bank_flat[j*BW +: BW] == bank_flat[i*BW +: BW])
                    lead_key = key_flat[j*AW +: AW];
            end
        end
        assign grant[i] = pending[i] && (lead_key == key_flat[i*AW +: AW]);
    end
endmodule

// File: rtl/sp_store.sv
// Word storage of the scratchpad, addressed by 32-bit word address.
// Reads are combinational and show the value before this cycle's writes.
// Writes are applied in ascending lane order, so on a shared address the
// highest lane's data lands. Not reset; contents are undefined until written.
module sp_store import sp_pkg::*; #(
    parameter int LANES = 32,
    parameter int AW    = 9
) (
    input  logic                clk,
    input  logic [LANES-1:0]    wr_en,
    input  logic [LANES*AW-1:0] addr_flat,
    input  logic [LANES*DW-1:0] wdata_flat,
    output logic [LANES*DW-1:0] rd_flat
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Apply this pass's writes; a later lane overrides an earlier one.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (wr_en[i])
                mem[addr_flat[i*AW +: AW]] <= wdata_flat[i*DW +: DW];
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_rd
        assign rd_flat[i*DW +: DW] = mem[addr_flat[i*AW +: AW]];
    end
endmodule

// File: rtl/sp_scratchpad.sv
// Banked scratchpad top. Takes one warp request while idle, then runs one
// pass per cycle until no lane is pending, and pulses done. Read data is
// captured per lane as its pass is granted. Assumes BANKS is a power of two.
module sp_scratchpad import sp_pkg::*; #(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    parameter int AW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [LANES-1:0]    req_mask,
    input  logic [LANES-1:0]    req_we,
    input  logic [LANES*AW-1:0] req_addr,
    input  logic [LANES*DW-1:0] req_wdata,
    input  logic                wide_mode,
    output logic                busy,
    output logic                done,
    output logic [LANES*DW-1:0] rdata
);
    localparam int BW = $clog2(BANKS);

    logic                busy_q, done_q;
    logic [LANES-1:0]    pend_q, we_q, grant, wr_en, pend_nx;
    logic [LANES*AW-1:0] addr_q, key_flat;
    logic [LANES*BW-1:0] bank_flat;
    logic [LANES*DW-1:0] wdata_q, rd_flat, rdata_q;
    ilv_mode_e           mode_q;

    sp_bank_map #(.LANES(LANES), .AW(AW), .BW(BW)) u_map (
        .addr_flat(addr_q),
        .wide     (mode_q == IL_WIDE),
        .bank_flat(bank_flat),
        .key_flat (key_flat)
    );

    sp_grant #(.LANES(LANES), .AW(AW), .BW(BW)) u_grant (
        .pending  (pend_q),
        .bank_flat(bank_flat),
        .key_flat (key_flat),
        .grant    (grant)
    );

    sp_store #(.LANES(LANES), .AW(AW)) u_store (
        .clk       (clk),
        .wr_en     (wr_en),
        .addr_flat (addr_q),
        .wdata_flat(wdata_q),
        .rd_flat   (rd_flat)
    );

    assign wr_en   = grant & we_q & {LANES{busy_q}};
    assign pend_nx = pend_q & ~grant;

    // Request acceptance, pass sequencing and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            pend_q  <= '0;
            we_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            mode_q  <= IL_NARROW;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                pend_q <= pend_nx;
                for (int i = 0; i < LANES; i++) begin
                    if (grant[i] && !we_q[i])
                        rdata_q[i*DW +: DW] <= rd_flat[i*DW +: DW];
                end
                if (pend_nx == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end else if (req_valid) begin
                busy_q  <= 1'b1;
                pend_q  <= req_mask;
                we_q    <= req_we;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mode_q  <= wide_mode ? IL_WIDE : IL_NARROW;
                rdata_q <= '0;
            end
        end
    end

    assign busy  = busy_q;
    assign done  = done_q;
    assign rdata = rdata_q;

    // R11: done lasts one cycle.
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done held longer than one cycle");

    // R2: completion is signalled exactly when busy drops.
    assert_done_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done) else $error("busy fell without done");

    // R2: every pass while lanes remain serves at least one of them.
    assert_pass_progress_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pend_q != '0) |-> (grant != '0)) else $error("pass granted no lane");

    // R6: only pending lanes may be granted.
    assert_grant_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((grant & ~pend_q) == '0)) else $error("grant to a lane not pending");

    // R10: while busy, the pending set only shrinks (no new request is taken).
    assert_no_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((pend_q & ~$past(pend_q)) == '0)) else $error("pending grew while busy");
endmodule

// File: tb/sp_scratchpad_test.sv
module sp_scratchpad_test;
    localparam int LANES = 32;
    localparam int BANKS = 32;
    localparam int AW    = 9;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic                t_valid = 1'b0, t_wide = 1'b0;
    logic [LANES-1:0]    t_mask = '0, t_we = '0;
    logic [AW-1:0]       t_addr [LANES];
    logic [31:0]         t_data [LANES];
    logic [LANES*AW-1:0] addr_f;
    logic [LANES*32-1:0] data_f;
    logic                busy, done;
    logic [LANES*32-1:0] rdata;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            addr_f[i*AW +: AW] = t_addr[i];
            data_f[i*32 +: 32] = t_data[i];
        end
    end

    sp_scratchpad #(.LANES(LANES), .BANKS(BANKS), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(t_valid), .req_mask(t_mask),
        .req_we(t_we), .req_addr(addr_f), .req_wdata(data_f),
        .wide_mode(t_wide), .busy(busy), .done(done), .rdata(rdata)
    );

    int total = 0, bad = 0;
    bit cmp_on = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0]      mm [DEPTH];
    bit               m_busy, m_done, m_wide;
    bit [LANES-1:0]   m_pend, m_we;
    logic [AW-1:0]    m_addr [LANES];
    logic [31:0]      m_wd [LANES];
    logic [31:0]      m_rd [LANES];

    function automatic int word_of(input logic [AW-1:0] a, input bit wide);
        return wide ? int'(a) / 2 : int'(a);
    endfunction

    function automatic int bank_of(input logic [AW-1:0] a, input bit wide);
        return word_of(a, wide) % BANKS;
    endfunction

    function automatic void model_pass();
        bit g [LANES];
        int lead;
        for (int i = 0; i < LANES; i++) g[i] = 1'b0;
        for (int b = 0; b < BANKS; b++) begin
            lead = -1;
            for (int i = 0; i < LANES; i++)
                if (lead < 0 && m_pend[i] && bank_of(m_addr[i], m_wide) == b) lead = i;
            if (lead >= 0)
                for (int i = 0; i < LANES; i++)
                    if (m_pend[i] && word_of(m_addr[i], m_wide) == word_of(m_addr[lead], m_wide))
                        g[i] = 1'b1;
        end
        for (int i = 0; i < LANES; i++)
            if (g[i] && !m_we[i]) m_rd[i] = mm[m_addr[i]];
        for (int i = 0; i < LANES; i++)
            if (g[i] && m_we[i]) mm[m_addr[i]] = m_wd[i];
        for (int i = 0; i < LANES; i++)
            if (g[i]) m_pend[i] = 1'b0;
        if (m_pend == '0) begin
            m_busy = 1'b0;
            m_done = 1'b1;
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_pend = '0;
            for (int i = 0; i < LANES; i++) m_rd[i] = '0;
        end else begin
            m_done = 1'b0;
            if (m_busy) model_pass();
            else if (t_valid) begin
                m_busy = 1'b1; m_pend = t_mask; m_we = t_we; m_wide = t_wide;
                for (int i = 0; i < LANES; i++) begin
                    m_addr[i] = t_addr[i]; m_wd[i] = t_data[i]; m_rd[i] = '0;
                end
            end
        end
    end

    // Compare outputs with the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(busy == m_busy, "R2", "model busy", 32'(busy), 32'(m_busy));
            chk(done == m_done, "R2", "model done", 32'(done), 32'(m_done));
            for (int i = 0; i < LANES; i++) begin
                if (rdata[i*32 +: 32] !== m_rd[i]) begin
                    chk(1'b0, "R6", $sformatf("model rdata lane %0d", i), rdata[i*32 +: 32], m_rd[i]);
                    break;
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] iv(input int a);
        return 32'h5A00_0000 + 32'(a);
    endfunction

    function automatic logic [31:0] rd(input int i);
        return rdata[i*32 +: 32];
    endfunction

    task automatic clr();
        t_mask = '0; t_we = '0;
        for (int i = 0; i < LANES; i++) begin t_addr[i] = '0; t_data[i] = '0; end
    endtask

    task automatic lane(input int i, input int a, input bit w, input logic [31:0] d);
        t_mask[i] = 1'b1; t_we[i] = w; t_addr[i] = AW'(a); t_data[i] = d;
    endtask

    task automatic run(input int exp_p, input string tag);
        int got = 0;
        t_valid = 1'b1;
        @(negedge clk);
        t_valid = 1'b0;
        while (!done) begin
            if (busy) got++;
            @(negedge clk);
        end
        chk(got == exp_p, tag, "pass count", 32'(got), 32'(exp_p));
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        clr();
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(busy == 1'b0 && done == 1'b0, "R12", "busy/done in reset", {busy, done}, 0);
        chk(rdata == '0, "R12", "rdata in reset", rd(0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;

        // R1: fill memory with stride-1 writes, one pass each
        for (int r = 0; r < DEPTH / LANES; r++) begin
            clr();
            for (int i = 0; i < LANES; i++) lane(i, r*LANES + i, 1'b1, iv(r*LANES + i));
            run(1, "R1");
        end
        // R9: write lanes return zero
        chk(rd(0) == 0, "R9", "write lane rdata", rd(0), 0);

        // R1: stride-1 reads
        clr();
        for (int i = 0; i < LANES; i++) lane(i, 100 + i, 1'b0, 0);
        run(1, "R1");
        chk(rd(7) == iv(107), "R1", "stride-1 lane 7", rd(7), iv(107));
        // R9: data held after done
        repeat (3) @(negedge clk);
        chk(rd(7) == iv(107), "R9", "rdata held", rd(7), iv(107));

        // R4: stride-2 in narrow then wide mode
        clr();
        for (int i = 0; i < LANES; i++) lane(i, 2*i, 1'b0, 0);
        run(2, "R4");
        t_wide = 1'b1;
        run(1, "R4");
        chk(rd(5) == iv(10), "R4", "wide stride-2 lane 5", rd(5), iv(10));
        // R4: both halves of a 64-bit word in one pass
        clr();
        for (int i = 0; i < LANES; i++) lane(i, 40 + (i % 2), 1'b0, 0);
        run(1, "R4");
        chk(rd(3) == iv(41), "R4", "wide pair lane 3", rd(3), iv(41));
        t_wide = 1'b0;

        // R5: stride-3
        clr();
        for (int i = 0; i < LANES; i++) lane(i, 3*i, 1'b0, 0);
        run(1, "R5");
        chk(rd(31) == iv(93), "R5", "stride-3 lane 31", rd(31), iv(93));

        // R3: broadcast read
        clr();
        for (int i = 0; i < LANES; i++) lane(i, 10, 1'b0, 0);
        run(1, "R3");
        chk(rd(30) == iv(10), "R3", "broadcast lane 30", rd(30), iv(10));

        // R2: 32-way and 4-way conflicts
        clr();
        for (int i = 0; i < LANES; i++) lane(i, i*BANKS % DEPTH, 1'b0, 0);
        run(LANES * BANKS > DEPTH ? DEPTH / BANKS : LANES, "R2");
        clr();
        for (int i = 0; i < LANES; i++) lane(i, (i % 8) + (i / 8) * BANKS, 1'b0, 0);
        run(4, "R2");
        chk(rd(9) == iv(33), "R2", "4-way lane 9", rd(9), iv(33));

        // R7: same-address writes, highest lane wins
        clr();
        for (int i = 0; i < LANES; i++) lane(i, 20, 1'b1, 32'(i));
        run(1, "R7");
        clr();
        lane(0, 20, 1'b0, 0);
        run(1, "R7");
        chk(rd(0) == 31, "R7", "winning write", rd(0), 31);

        // R6: lowest lane leads; read sees pre-pass value
        clr();
        lane(0, 20, 1'b1, 32'h1111);
        lane(1, 52, 1'b1, 32'h2222);
        lane(2, 20, 1'b0, 0);
        run(2, "R6");
        chk(rd(2) == 31, "R6", "read before same-pass write", rd(2), 31);
        clr();
        lane(0, 20, 1'b0, 0);
        lane(1, 52, 1'b0, 0);
        run(2, "R6");
        chk(rd(0) == 32'h1111 && rd(1) == 32'h2222, "R6", "both writes landed", rd(1), 32'h2222);

        // R8: inactive lanes neither conflict nor write
        clr();
        lane(0, 0, 1'b0, 0);
        lane(1, 1, 1'b0, 0);
        for (int i = 2; i < LANES; i++) begin
            t_addr[i] = AW'((i * BANKS) % DEPTH); t_we[i] = 1'b1; t_data[i] = 32'hBAD0_0000;
        end
        run(1, "R8");
        chk(rd(5) == 0, "R8", "inactive lane rdata", rd(5), 0);
        clr();
        lane(0, 64, 1'b0, 0);
        run(1, "R8");
        chk(rd(0) == iv(64), "R8", "inactive write ignored", rd(0), iv(64));

        // R10: request raised while busy is ignored
        clr();
        for (int i = 0; i < 16; i++) lane(i, i*BANKS, 1'b0, 0);
        t_valid = 1'b1;
        @(negedge clk);
        t_valid = 1'b0;
        @(negedge clk);
        clr();
        lane(0, 30, 1'b1, 32'hDEAD_BEEF);
        t_valid = 1'b1;
        repeat (2) @(negedge clk);
        t_valid = 1'b0;
        while (!done) @(negedge clk);
        clr();
        lane(0, 30, 1'b0, 0);
        run(1, "R10");
        chk(rd(0) == iv(30), "R10", "busy-time write ignored", rd(0), iv(30));

        // R11: empty request, single-cycle done
        clr();
        run(1, "R11");
        chk(rdata == '0, "R11", "empty request rdata", rd(0), 0);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done dropped", 32'(done), 0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule